// File: doc/BRIEF.md
# Register-index extension prefix unit

This decode-stage block widens the 5-bit register specifiers of an instruction to 8-bit indices, so that a 256-entry register file can be reached. A prefix instruction carries two groups of extension bits. Each group holds a valid flag, four 3-bit upper fields (destination and three sources, enough for a fused multiply-add) and a SIMD flag. When the prefix is decoded, both groups are loaded into a two-entry queue. Each later instruction that retires uses up the head group. The second group then moves to the head, so the two groups apply in program order to the next two instructions.

For an instruction, the unit joins the head group's upper bits with the instruction's own low fields and reports whether an extension applied. It also reports the group's SIMD flag. When the head group is not valid, the upper bits are zero, which gives the legacy 32-register view. A prefix whose second group is marked not valid extends only one instruction. A flush discards both groups at once.

Top module: `regidx_ext`

## Requirements
- R1: After reset (asynchronous, active low), both groups are empty. Every index output equals its zero-extended low field, and `simd_o` and `ext_hit_o` are 0.
- R2: When `ins_valid_i` and `ins_prefix_i` are both high at a clock edge, the group in bits [31:16] of `ins_word_i` becomes the head and the group in bits [15:0] becomes the second entry. Within each 16-bit half: bit 13 is valid, bits [12:10] are rd upper, [9:7] are rs1 upper, [6:4] are rs2 upper, [3:1] are rs3 upper, and bit 0 is SIMD.
- R3: While the head group is valid, each of the four index outputs is {upper 3 bits from the head group, 5-bit low input}. `ext_hit_o` is 1 and `simd_o` equals the group's SIMD bit.
- R4: While the head group is not valid, the upper bits are zero and `simd_o` is 0, whatever payload that group carries.
- R5: A `retire_i` pulse (a non-prefix instruction has executed) moves the second group to the head and empties the second entry.
- R6: A prefix with its lower-half valid bit at 0 extends exactly one instruction; after one retire the legacy view returns.
- R7: A new prefix replaces any groups that are still valid.
- R8: `flush_i` empties both entries at that clock edge and takes priority over a prefix load and a retire in the same cycle.
- R9: When a prefix load and a retire coincide without flush, the new prefix is loaded and nothing is shifted.
- R10: With `ins_valid_i` low, `ins_prefix_i` and `ins_word_i` have no effect on the stored groups.
- R11: Bits [15:14] of each half are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard both extension groups |
| ins_valid_i | input | 1 | A decoded instruction is present |
| ins_prefix_i | input | 1 | The present instruction is a prefix |
| ins_word_i | input | 32 | Prefix payload, two 16-bit groups |
| retire_i | input | 1 | A non-prefix instruction has executed |
| rd_lo_i | input | 5 | Destination low field |
| rs1_lo_i | input | 5 | Source 1 low field |
| rs2_lo_i | input | 5 | Source 2 low field |
| rs3_lo_i | input | 5 | Source 3 low field |
| rd_idx_o | output | 8 | Extended destination index |
| rs1_idx_o | output | 8 | Extended source 1 index |
| rs2_idx_o | output | 8 | Extended source 2 index |
| rs3_idx_o | output | 8 | Extended source 3 index |
| simd_o | output | 1 | SIMD flag of the applied group |
| ext_hit_o | output | 1 | An extension group applied |

## Verification
The bench targets the following corner cases:
- A prefix arriving on the same edge as a retire or a flush. A design with the wrong priority would shift away a freshly loaded group, or keep groups after a flush.
- Overwriting a queue that still holds a pending second group. If this is done wrong, a stale group leaks onto a later instruction.
- A head group marked invalid but full of nonzero payload, and a prefix with set pad bits. A design that ignores the valid bit, or reads the pad, would produce wrong upper index bits.
- A prefix word presented without `ins_valid_i`. A design that loads on `ins_prefix_i` alone would extend the next instruction.

// File: rtl/regidx_pkg.sv
package regidx_pkg;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = 3;
  localparam int unsigned NFLD   = 4;
  localparam int unsigned IDX_W  = LO_W + HI_W;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned GRP_W  = 1 + NFLD * HI_W + 1;

  // hi[0]=rd, hi[1]=rs1, hi[2]=rs2, hi[3]=rs3
  typedef struct packed {
    logic                       valid;
    logic [NFLD-1:0][HI_W-1:0]  hi;
    logic                       simd;
  } grp_t;
endpackage

// File: rtl/regidx_grp_unpack.sv
module regidx_grp_unpack
  import regidx_pkg::*;
#(
  parameter int unsigned HALF = HALF_W
) (
  input  logic [HALF-1:0] half_i,
  output grp_t            grp_o
);
  logic [NFLD-1:0][HI_W-1:0] hi_w;

  // rd sits highest, just under the valid bit
  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    assign hi_w[f] = half_i[1 + (NFLD - f) * HI_W - 1 -: HI_W];
  end

  if (HALF > GRP_W) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^half_i[HALF-1:GRP_W];
  end

  always_comb begin
    grp_o.valid = half_i[GRP_W-1];
    grp_o.hi    = hi_w;
    grp_o.simd  = half_i[0];
  end
endmodule

// File: rtl/regidx_slot_q.sv
module regidx_slot_q
  import regidx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic load_i,
  input  logic retire_i,
  input  grp_t grp_a_i,
  input  grp_t grp_b_i,
  output grp_t head_o
);
  grp_t slot0_q, slot1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
    end else if (flush_i) begin
      slot0_q <= '0;
      slot1_q <= '0;
    end else if (load_i) begin
      slot0_q <= grp_a_i;
      slot1_q <= grp_b_i;
    end else if (retire_i) begin
      slot0_q <= slot1_q;
      slot1_q <= '0;
    end
  end

  assign head_o = slot0_q;

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!slot0_q.valid && !slot1_q.valid));

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i) |=> (slot0_q == $past(grp_a_i) && slot1_q == $past(grp_b_i)));

  p_retire_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !load_i && !flush_i) |=> (slot0_q == $past(slot1_q) && !slot1_q.valid));

  p_tail_only_by_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot1_q.valid) |-> $past(load_i));
endmodule

// File: rtl/regidx_widen.sv
module regidx_widen
  import regidx_pkg::*;
(
  input  grp_t                       head_i,
  input  logic [NFLD-1:0][LO_W-1:0]  lo_i,
  output logic [NFLD-1:0][IDX_W-1:0] idx_o,
  output logic                       simd_o,
  output logic                       hit_o
);
  for (genvar f = 0; f < NFLD; f++) begin : g_idx
    assign idx_o[f] = {(head_i.valid ? head_i.hi[f] : {HI_W{1'b0}}), lo_i[f]};
  end

  assign simd_o = head_i.valid & head_i.simd;
  assign hit_o  = head_i.valid;
endmodule

// File: rtl/regidx_ext.sv
module regidx_ext
  import regidx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ins_valid_i,
  input  logic              ins_prefix_i,
  input  logic [WORD_W-1:0] ins_word_i,
  input  logic              retire_i,
  input  logic [LO_W-1:0]   rd_lo_i,
  input  logic [LO_W-1:0]   rs1_lo_i,
  input  logic [LO_W-1:0]   rs2_lo_i,
  input  logic [LO_W-1:0]   rs3_lo_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [IDX_W-1:0]  rs1_idx_o,
  output logic [IDX_W-1:0]  rs2_idx_o,
  output logic [IDX_W-1:0]  rs3_idx_o,
  output logic              simd_o,
  output logic              ext_hit_o
);
  grp_t grp_a, grp_b, head;
  logic load;
  logic [NFLD-1:0][LO_W-1:0]  lo;
  logic [NFLD-1:0][IDX_W-1:0] idx;

  assign load = ins_valid_i & ins_prefix_i;
  assign lo   = {rs3_lo_i, rs2_lo_i, rs1_lo_i, rd_lo_i};

  regidx_grp_unpack #(.HALF(HALF_W)) u_unp_a (
    .half_i (ins_word_i[WORD_W-1:HALF_W]),
    .grp_o  (grp_a)
  );

  regidx_grp_unpack #(.HALF(HALF_W)) u_unp_b (
    .half_i (ins_word_i[HALF_W-1:0]),
    .grp_o  (grp_b)
  );

  regidx_slot_q u_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .load_i   (load),
    .retire_i (retire_i),
    .grp_a_i  (grp_a),
    .grp_b_i  (grp_b),
    .head_o   (head)
  );

  regidx_widen u_wid (
    .head_i (head),
    .lo_i   (lo),
    .idx_o  (idx),
    .simd_o (simd_o),
    .hit_o  (ext_hit_o)
  );

  assign rd_idx_o  = idx[0];
  assign rs1_idx_o = idx[1];
  assign rs2_idx_o = idx[2];
  assign rs3_idx_o = idx[3];

  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_valid_i && !retire_i && !flush_i) |=> ($stable(ext_hit_o) && $stable(simd_o)));

  p_low_passthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_o[LO_W-1:0] == rd_lo_i) && (rs3_idx_o[LO_W-1:0] == rs3_lo_i));

  p_legacy_after_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!ext_hit_o && !simd_o));
endmodule

// File: tb/sim_regidx_ext.sv
`timescale 1ns/1ps
module sim_regidx_ext;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0, ins_valid_i = 1'b0, ins_prefix_i = 1'b0, retire_i = 1'b0;
  logic [31:0] ins_word_i = '0;
  logic [4:0] rd_lo_i = '0, rs1_lo_i = '0, rs2_lo_i = '0, rs3_lo_i = '0;
  logic [7:0] rd_idx_o, rs1_idx_o, rs2_idx_o, rs3_idx_o;
  logic simd_o, ext_hit_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regidx_ext u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .ins_valid_i(ins_valid_i),
    .ins_prefix_i(ins_prefix_i), .ins_word_i(ins_word_i), .retire_i(retire_i),
    .rd_lo_i(rd_lo_i), .rs1_lo_i(rs1_lo_i), .rs2_lo_i(rs2_lo_i), .rs3_lo_i(rs3_lo_i),
    .rd_idx_o(rd_idx_o), .rs1_idx_o(rs1_idx_o), .rs2_idx_o(rs2_idx_o), .rs3_idx_o(rs3_idx_o),
    .simd_o(simd_o), .ext_hit_o(ext_hit_o)
  );

  // groups: G1=3CA7 (7,1,2,3 simd) G2=2A5C (2,4,5,6) G3=F772 (5,6,7,1, pad set)
  // {flush,valid,prefix,retire, word, exp_hit, exp_simd, exp_hi[rd,rs1,rs2,rs3]}
  localparam int NV = 26;
  localparam logic [49:0] VEC [NV] = '{
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 0  R1 reset view
    {4'b0110, 32'h3CA7_2A5C, 2'b00, 12'h000},  // 1  R2 load
    {4'b0101, 32'h0000_0000, 2'b11, 12'hE53},  // 2  R3 head G1
    {4'b0101, 32'h0000_0000, 2'b10, 12'h52E},  // 3  R5 shifted G2
    {4'b0101, 32'h0000_0000, 2'b00, 12'h000},  // 4  R5 empty
    {4'b0110, 32'h3CA7_0000, 2'b00, 12'h000},  // 5  R6 single variant
    {4'b0101, 32'h0000_0000, 2'b11, 12'hE53},  // 6  R6
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 7  R6 legacy again
    {4'b0110, 32'h2A5C_F772, 2'b00, 12'h000},  // 8  R7 setup
    {4'b0110, 32'h3CA7_0000, 2'b10, 12'h52E},  // 9  R7 overwrite
    {4'b0101, 32'h0000_0000, 2'b11, 12'hE53},  // 10 R7
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 11 R7 old tail gone
    {4'b0110, 32'hF772_2A5C, 2'b00, 12'h000},  // 12 R11 pad bits
    {4'b1111, 32'h3CA7_3CA7, 2'b10, 12'hBB9},  // 13 R11 head G3, flush+load+retire
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 14 R8 flush wins
    {4'b0110, 32'h3CA7_2A5C, 2'b00, 12'h000},  // 15 R9 setup
    {4'b0111, 32'h2A5C_0000, 2'b11, 12'hE53},  // 16 R9 load+retire
    {4'b0101, 32'h0000_0000, 2'b10, 12'h52E},  // 17 R9 new head, not shifted
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 18 R9 tail empty
    {4'b0010, 32'h3CA7_2A5C, 2'b00, 12'h000},  // 19 R10 prefix w/o valid
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000},  // 20 R10 no load
    {4'b0110, 32'h1FFF_2A5C, 2'b00, 12'h000},  // 21 R4 invalid head with payload
    {4'b0101, 32'h0000_0000, 2'b00, 12'h000},  // 22 R4 legacy
    {4'b0000, 32'h0000_0000, 2'b10, 12'h52E},  // 23 R5 tail promoted
    {4'b0101, 32'h0000_0000, 2'b10, 12'h52E},  // 24 R5
    {4'b0000, 32'h0000_0000, 2'b00, 12'h000}   // 25 R5 empty
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1";
      1, 2: return "R2/R3";
      3, 4, 23, 24, 25: return "R5";
      5, 6, 7: return "R6";
      8, 9, 10, 11: return "R7";
      12, 13: return "R11";
      14: return "R8";
      15, 16, 17, 18: return "R9";
      19, 20: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] outs();
    return {rd_idx_o, rs1_idx_o, rs2_idx_o, rs3_idx_o, simd_o, ext_hit_o};
  endfunction

  function automatic logic [33:0] expect_of(logic [11:0] hi, logic s, logic h);
    return {hi[11:9], rd_lo_i, hi[8:6], rs1_lo_i, hi[5:3], rs2_lo_i, hi[2:0], rs3_lo_i, s, h};
  endfunction

  task automatic idle_inputs();
    flush_i = 1'b0; ins_valid_i = 1'b0; ins_prefix_i = 1'b0; retire_i = 1'b0;
    ins_word_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {flush_i, ins_valid_i, ins_prefix_i, retire_i} = VEC[i][49:46];
      ins_word_i = VEC[i][45:14];
      rd_lo_i  = 5'(i * 3 + 1);
      rs1_lo_i = 5'(i * 5 + 2);
      rs2_lo_i = 5'(31 - i);
      rs3_lo_i = 5'(i * 11);
      #1;
      check(vec_req(i), outs(), expect_of(VEC[i][11:0], VEC[i][12], VEC[i][13]));
    end

    // R8: flush alone after a two-group load
    @(negedge clk);
    idle_inputs();
    ins_valid_i = 1'b1; ins_prefix_i = 1'b1; ins_word_i = 32'h3CA7_2A5C;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R3", outs(), expect_of(12'hE53, 1'b1, 1'b1));
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    #1;
    check("R8", outs(), expect_of(12'h000, 1'b0, 1'b0));
    retire_i = 1'b1;
    @(negedge clk);
    retire_i = 1'b0;
    #1;
    check("R8", outs(), expect_of(12'h000, 1'b0, 1'b0));

    // R1: asynchronous reset mid-operation
    ins_valid_i = 1'b1; ins_prefix_i = 1'b1; ins_word_i = 32'h3CA7_2A5C;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R2", outs(), expect_of(12'hE53, 1'b1, 1'b1));
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1", outs(), expect_of(12'h000, 1'b0, 1'b0));
    @(negedge clk);
    rst_ni = 1'b1;
    retire_i = 1'b1;
    @(negedge clk);
    retire_i = 1'b0;
    #1;
    check("R1", outs(), expect_of(12'h000, 1'b0, 1'b0));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule